// File: doc/BRIEF.md
# Auto-Baud Key-State Serial Responder

This block is the slave side of a one-wire serial link. A host sends a single fixed request character on a shared, pulled-up bidirectional line, or on a separate receive-only pin. The block measures the host's bit rate from that character and then answers at the same rate with two bytes that report the on/off state of ten keys. It turns the shared line around itself. It leaves the line floating while it listens, drives it push-pull while it answers, and lets go again once each stop level is set up.

A change flag tells the host when there is something new to read. The flag is an open-drain pull-down that is active whenever the live key vector differs from the one last reported. The flag is released as soon as a request is accepted, so the host can wait on the flag instead of polling.

Top module: `keystat_autobaud_tx`

## Requirements
- R1: The only request accepted is the character 0x50, sent LSB first with one low start bit, 8 data bits, no parity and one high stop bit. Any other character gets no reply and leaves the change flag unchanged.
- R2: The bit period is the length of the low run formed by the start bit and data bits 0 to 3, divided by 5. A request whose measured period lies outside the band set by MIN_BAUD..MAX_BAUD, with a 1/16 margin, gets no reply.
- R3: The reply is two bytes, each sent LSB first as one low start bit, 8 data bits and one high stop bit, with each bit lasting the measured period. The first byte is {0, 1, key[5:0]}. The second byte is {0, 1, 0, 0, key[9:6]}. With no key active, both bytes are 0x40.
- R4: Driving of the reply begins between 1 and 3 measured bit periods after the end of the request stop bit.
- R5: `line_oe` is high for every start bit and data bit of the reply. For each reply stop bit, the high level is driven for the first half of the bit and the line is then released. At all other times `line_oe` is low.
- R6: While the block is idle, `chg_pull` is high exactly when `keys` differs from the last reported vector. It is low from the acceptance of a request until the reply is over, and so it is low when driving starts.
- R7: A request on `rx_in` is accepted in the same way as one on `line_in`, and the reply is still driven on the bidirectional line.
- R8: The key vector is captured when the request is accepted. Changes to `keys` during the reply do not alter either byte.
- R9: During and straight after reset, `line_oe` and `chg_pull` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Sampled level of the shared line (high when floating) |
| rx_in | input | 1 | Separate receive-only request pin, idle high |
| keys | input | 10 | Live key states, 1 = active |
| line_oe | output | 1 | Push-pull drive enable for the shared line |
| line_out | output | 1 | Level driven onto the shared line when enabled |
| chg_pull | output | 1 | Pull the open-drain change pin low (flag active) |

## Verification
The assertions assume that the host never drives the shared line while `line_oe` is high. They also assume that both receive inputs idle high, so the only edges the block sees come from real characters. The stimulus models the line as the block's output when it is enabled and the host's level otherwise, with the host driving only during its own request. Requests that are too fast, too slow or the wrong character still toggle the line in legal ways. The bench then waits until the block is idle again before starting the next vector.

// File: rtl/keystat_autobaud_tx.sv
module keystat_autobaud_tx #(
  parameter int CLK_HZ   = 50_000_000,
  parameter int MIN_BAUD = 8000,
  parameter int MAX_BAUD = 38400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_in,
  input  logic       rx_in,
  input  logic [9:0] keys,
  output logic       line_oe,
  output logic       line_out,
  output logic       chg_pull
);
  localparam int PMIN = CLK_HZ / MAX_BAUD;
  localparam int PMAX = CLK_HZ / MIN_BAUD;
  localparam int PLO  = PMIN - PMIN / 16;
  localparam int PHI  = PMAX + PMAX / 16;
  localparam int CW   = $clog2(8 * PMAX + 1);
  localparam logic [4:0] TAIL = 5'b10101;

  typedef enum logic [2:0] {S_IDLE, S_LOW, S_BITS, S_GAP, S_TX} st_t;

  st_t             st;
  logic [2:0]      rxs;
  logic [CW-1:0]   cnt, per;
  logic [4:0]      idx;
  logic [19:0]     frame;
  logic [9:0]      rep;

  wire rxd  = line_in & rx_in;
  wire fall = rxs[2] & ~rxs[1];
  wire rise = ~rxs[2] & rxs[1];
  wire [CW-1:0] per_m = cnt / CW'(5);
  wire per_ok = (per_m >= CW'(PLO)) && (per_m <= CW'(PHI));
  wire stop_pos = (idx == 5'd9) || (idx == 5'd19);

  assign line_out = frame[0];
  assign line_oe  = (st == S_TX) && !(stop_pos && (cnt < (per >> 1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      rxs      <= 3'b111;
      cnt      <= '0;
      per      <= '0;
      idx      <= '0;
      frame    <= '1;
      rep      <= '0;
      chg_pull <= 1'b0;
    end else begin
      rxs <= {rxs[1:0], rxd};
      case (st)
        S_IDLE: begin
          chg_pull <= (keys != rep);
          if (fall) begin
            cnt <= CW'(1);
            st  <= S_LOW;
          end
        end
        S_LOW: begin
          if (rise) begin
            if (per_ok) begin
              per <= per_m;
              cnt <= per_m >> 1;
              idx <= '0;
              st  <= S_BITS;
            end else begin
              st <= S_IDLE;
            end
          end else if (cnt != '1) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_BITS: begin
          if (cnt == '0) begin
            if (rxs[1] != TAIL[idx[2:0]]) begin
              st <= S_IDLE;
            end else if (idx == 5'd4) begin
              rep      <= keys;
              chg_pull <= 1'b0;
              frame    <= {1'b1, 4'b0100, keys[9:6], 1'b0, 1'b1, 2'b01, keys[5:0], 1'b0};
              cnt      <= CW'(per << 1);
              st       <= S_GAP;
            end else begin
              idx <= idx + 1'b1;
              cnt <= per - 1'b1;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_GAP: begin
          if (cnt == '0) begin
            idx <= '0;
            cnt <= per - 1'b1;
            st  <= S_TX;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_TX: begin
          if (cnt == '0) begin
            frame <= {1'b1, frame[19:1]};
            if (idx == 5'd19) begin
              st <= S_IDLE;
            end else begin
              idx <= idx + 1'b1;
              cnt <= per - 1'b1;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/keystat_autobaud_tx_chk.sv
module keystat_autobaud_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       line_oe,
  input logic       line_out,
  input logic       chg_pull,
  input logic [9:0] rep
);
  a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_oe) |-> !line_out);

  a_r5_release_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_oe) |-> $past(line_out));

  a_r6_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_oe) |-> !chg_pull);

  a_r8_keys_held: assert property (@(posedge clk) disable iff (!rst_n)
    line_oe |-> $stable(rep));
endmodule

bind keystat_autobaud_tx keystat_autobaud_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .line_oe(line_oe), .line_out(line_out),
  .chg_pull(chg_pull), .rep(rep)
);

// File: tb/keystat_autobaud_tx_tb.sv
module keystat_autobaud_tx_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_bit = 1'b1;
  logic rx_in = 1'b1;
  logic [9:0] keys = '0;
  logic line_oe, line_out, chg_pull;
  int nchk = 0, nfail = 0;
  logic [9:0] lastrep = '0;

  wire line_in = line_oe ? line_out : host_bit;

  always #10 clk = ~clk;

  keystat_autobaud_tx #(.CLK_HZ(5_000_000)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .rx_in(rx_in), .keys(keys),
    .line_oe(line_oe), .line_out(line_out), .chg_pull(chg_pull)
  );

  // {period cycles, char, keys, use rx pin, reply expected}
  localparam logic [35:0] VEC [10] = '{
    {16'd300, 8'h50, 10'h000, 1'b0, 1'b1},
    {16'd300, 8'h50, 10'h085, 1'b0, 1'b1},
    {16'd300, 8'h51, 10'h001, 1'b0, 1'b0},
    {16'd130, 8'h50, 10'h3FF, 1'b0, 1'b1},
    {16'd300, 8'h70, 10'h200, 1'b0, 1'b0},
    {16'd625, 8'h50, 10'h2AA, 1'b0, 1'b1},
    {16'd100, 8'h50, 10'h111, 1'b0, 1'b0},
    {16'd300, 8'h50, 10'h155, 1'b1, 1'b1},
    {16'd800, 8'h50, 10'h0F0, 1'b0, 1'b0},
    {16'd250, 8'h50, 10'h0F0, 1'b1, 1'b1}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input int per, input logic [7:0] ch, input bit use_rx);
    for (int b = 0; b < 10; b++) begin
      logic v;
      v = (b == 0) ? 1'b0 : (b == 9) ? 1'b1 : ch[b-1];
      if (use_rx) rx_in = v; else host_bit = v;
      tick(per);
    end
    host_bit = 1'b1;
    rx_in = 1'b1;
  endtask

  task automatic get_reply(input int per, input bit want, input string tag,
                           input logic [9:0] k);
    int c = 0;
    logic [19:0] got;
    bit oe_bad;
    logic [7:0] e0, e1;
    while (!line_oe && c < 4 * per) begin
      tick(1);
      c++;
    end
    if (!want) begin
      check(line_oe == 1'b0, tag, line_oe, 0);
      return;
    end
    check(line_oe && c >= per && c <= 3 * per, "R4 turnaround", c, 2 * per);
    check(chg_pull == 1'b0, "R6 flag at reply", chg_pull, 0);
    oe_bad = 1'b0;
    for (int k2 = 0; k2 < 20; k2++) begin
      bit is_stop;
      is_stop = (k2 == 9) || (k2 == 19);
      tick(per / 4);
      got[k2] = line_out;
      if (!line_oe) oe_bad = 1'b1;
      tick(per / 2);
      if (line_oe == is_stop) oe_bad = 1'b1;
      tick(per - per / 4 - per / 2);
    end
    e0 = {2'b01, k[5:0]};
    e1 = {4'b0100, k[9:6]};
    check(got[0] == 1'b0 && got[9] == 1'b1 && got[8:1] == e0, "R3 byte0", got[9:0], {1'b1, e0, 1'b0});
    check(got[10] == 1'b0 && got[19] == 1'b1 && got[18:11] == e1, "R3 byte1", got[19:10], {1'b1, e1, 1'b0});
    check(!oe_bad, "R5 drive/release", oe_bad, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    tick(3);
    check(line_oe == 1'b0 && chg_pull == 1'b0, "R9 in reset", {line_oe, chg_pull}, 0);
    rst_n = 1'b1;
    tick(3);
    check(line_oe == 1'b0 && chg_pull == 1'b0, "R9 after reset", {line_oe, chg_pull}, 0);

    for (int i = 0; i < 10; i++) begin
      int per;
      logic [7:0] ch;
      logic [9:0] k;
      bit use_rx, want;
      string tag;
      {per, ch, k, use_rx, want} = {16'd0, VEC[i]};
      per = int'(VEC[i][35:20]);
      keys = k;
      tick(4);
      check(chg_pull == (k != lastrep), "R6 flag idle", chg_pull, k != lastrep);
      tag = (ch != 8'h50) ? "R1 wrong char no reply" : "R2 rate out of band no reply";
      if (use_rx) tag = "R7 rx pin";
      send(per, ch, use_rx);
      get_reply(per, want, tag, k);
      if (want) lastrep = k;
      tick(per);
      if (!want) check(chg_pull == (k != lastrep), "R1 ignored request keeps flag", chg_pull, k != lastrep);
    end

    // R8: keys change mid-reply, reply keeps the captured vector
    keys = 10'h3C3;
    tick(4);
    fork
      begin
        send(200, 8'h50, 1'b0);
        get_reply(200, 1'b1, "R8", 10'h3C3);
      end
      begin
        wait (line_oe);
        tick(600);
        keys = 10'h000;
      end
    join
    tick(4);
    check(chg_pull == 1'b1, "R8 flag after change during reply", chg_pull, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule